// File: doc/BRIEF.md
# Binary Seconds Real-Time Counter with Masked Alarm

A memory-mapped timekeeping block that counts whole seconds as one wide binary number. A reference tick enable drives a programmable divider. Each time the divider wraps, the seconds count advances by one. Software sets the time in two steps. It first writes a shadow copy of the time, which leaves the live count untouched. It then issues an upload command, which copies the shadow into the live counter and raises a completion flag that software polls.

An alarm value is compared with the low bits of the counter through a per-bit compare mask, so a mask of all ones gives an exact match. When the alarm is armed and waking is enabled, a match sets a sticky interrupt. Mode bits choose what the counter does on that event: it keeps running, it stops, or it restarts from zero. Single-cycle command bits in the control word start, stop, arm, disarm, soft-reset, upload and force or clear the interrupt.

All registers are 32-bit words on a plain write-enable bus with a combinational read port. Word offsets: control 0x00, mode 0x04, divider 0x08, alarm low 0x0C, alarm high 0x10, mask low 0x14, mask high 0x18, time low 0x20, time high 0x24.

Top module: `bsec_rtc`

## Requirements
- R1: After reset the control word reads 0, the time reads 0, the interrupt is low, the divider is 0 and the mask is all ones.
- R2: Writing the time words (0x20 low, 0x24 high) changes only the shadow copy; reads of 0x20/0x24 keep returning the live counter.
- R3: Writing control bit 5 copies the shadow into the live counter on the next clock and sets control read bit 5; a later write to either time word clears that bit.
- R4: While running, the counter advances by one on every (divider value + 1)-th cycle with the reference tick high; cycles with the tick low do not count.
- R5: Writing control bit 1 stops counting; writing control bit 0 resumes it; read bit 0 shows running. Stop wins if both are written together.
- R6: With mode bit 1 (wake enable) set and the alarm armed (control bit 2), a match sets the interrupt, which stays set and reads back as control bit 7.
- R7: With mode bit 1 clear, a match never raises the interrupt.
- R8: Writing control bit 3 disarms the alarm (read bit 2 goes to 0) and clears the interrupt on the next clock.
- R9: A match is ((counter XOR alarm) AND mask) equal to zero over the 43 alarm bits, so mask bits at 0 are ignored.
- R10: With mode bit 3 (continue) clear, the counter stops on the cycle after the wake event; with it set, it keeps running.
- R11: With mode bit 2 (wake reset) set and the counter running, the wake event restarts the count from zero.
- R12: Writing control bit 4 clears the counter, the divider count and the interrupt, and stops counting.
- R13: Writing control bit 9 sets the interrupt and writing control bit 8 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference clock enable feeding the divider |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wake_irq | output | 1 | Sticky alarm interrupt |

## Verification
The assertions watch, on every cycle, that a stopped counter holds still when no command is written, that an upload lands the shadow value in the counter with the completion flag set, that disarm clears the interrupt, that the interrupt stays set once raised, and that it stays low while waking is disabled. The scenarios show what only a sequence can: the divider ratio over many reference ticks, exact and masked alarm matches, whether the counter stops or restarts on a wake event, and that the soft reset and the force and clear commands act on the interrupt.

// File: rtl/bsec_rtc.sv
module bsec_rtc #(
  parameter int PRE_W  = 26,
  parameter int CNT_W  = 62,
  parameter int ALM_W  = 43,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wake_irq
);

  localparam int CHI_W = CNT_W - 32;
  localparam int AHI_W = ALM_W - 32;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_ALO   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_AHI   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_MLO   = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_MHI   = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_TLO   = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_THI   = ADDR_W'(8'h24);

  logic             run_q, arm_q, upl_q, irq_q;
  logic [3:0]       mode_q;
  logic [PRE_W-1:0] div_q, div_cnt_q;
  logic [ALM_W-1:0] alarm_q;
  logic [CNT_W-1:0] mask_q, shadow_q, cnt_q;

  wire ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  wire c_start  = ctrl_wr && bus_wdata[0];
  wire c_stop   = ctrl_wr && bus_wdata[1];
  wire c_arm    = ctrl_wr && bus_wdata[2];
  wire c_disarm = ctrl_wr && bus_wdata[3];
  wire c_srst   = ctrl_wr && bus_wdata[4];
  wire c_upl    = ctrl_wr && bus_wdata[5];
  wire c_iclr   = ctrl_wr && bus_wdata[8];
  wire c_iset   = ctrl_wr && bus_wdata[9];
  wire t_wr     = bus_wr && ((bus_addr == A_TLO) || (bus_addr == A_THI));

  wire wake_en   = mode_q[1];
  wire wake_rst  = mode_q[2];
  wire wake_cont = mode_q[3];

  wire match_hit = (((cnt_q[ALM_W-1:0] ^ alarm_q) & mask_q[ALM_W-1:0]) == '0);
  wire wake_evt  = arm_q && wake_en && match_hit && !irq_q;
  wire div_wrap  = (div_cnt_q == div_q);
  wire sec_tick  = run_q && ref_tick && div_wrap;

  assign wake_irq = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      div_q    <= '0;
      alarm_q  <= '0;
      mask_q   <= '1;
      shadow_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE: mode_q <= bus_wdata[3:0];
        A_DIV:  div_q  <= bus_wdata[PRE_W-1:0];
        A_ALO:  alarm_q[31:0] <= bus_wdata;
        A_AHI:  alarm_q[ALM_W-1:32] <= bus_wdata[AHI_W-1:0];
        A_MLO:  mask_q[31:0] <= bus_wdata;
        A_MHI:  mask_q[CNT_W-1:32] <= bus_wdata[CHI_W-1:0];
        A_TLO:  shadow_q[31:0] <= bus_wdata;
        A_THI:  shadow_q[CNT_W-1:32] <= bus_wdata[CHI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      div_cnt_q <= '0;
    end else if (c_srst || c_upl) begin
      cnt_q     <= c_srst ? '0 : shadow_q;
      div_cnt_q <= '0;
    end else if (wake_evt && wake_rst && run_q) begin
      cnt_q     <= '0;
      div_cnt_q <= '0;
    end else if (run_q && ref_tick) begin
      div_cnt_q <= div_wrap ? '0 : div_cnt_q + 1'b1;
      if (sec_tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      arm_q <= 1'b0;
      upl_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (c_srst || c_stop || (wake_evt && !wake_cont)) run_q <= 1'b0;
      else if (c_start) run_q <= 1'b1;

      if (c_disarm) arm_q <= 1'b0;
      else if (c_arm) arm_q <= 1'b1;

      if (c_upl) upl_q <= 1'b1;
      else if (t_wr) upl_q <= 1'b0;

      if (c_srst || c_disarm || c_iclr) irq_q <= 1'b0;
      else if (c_iset || wake_evt) irq_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[0] = run_q;
        bus_rdata[2] = arm_q;
        bus_rdata[5] = upl_q;
        bus_rdata[7] = irq_q;
      end
      A_MODE: bus_rdata[3:0] = mode_q;
      A_DIV:  bus_rdata[PRE_W-1:0] = div_q;
      A_ALO:  bus_rdata = alarm_q[31:0];
      A_AHI:  bus_rdata[AHI_W-1:0] = alarm_q[ALM_W-1:32];
      A_MLO:  bus_rdata = mask_q[31:0];
      A_MHI:  bus_rdata[CHI_W-1:0] = mask_q[CNT_W-1:32];
      A_TLO:  bus_rdata = cnt_q[31:0];
      A_THI:  bus_rdata[CHI_W-1:0] = cnt_q[CNT_W-1:32];
      default: ;
    endcase
  end

endmodule

// File: rtl/bsec_rtc_chk.sv
module bsec_rtc_chk #(
  parameter int CNT_W  = 62,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              wake_irq,
  input logic              running,
  input logic              wake_en,
  input logic              upl_done,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  shadow
);

  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (bus_addr == '0);

  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ctrl_wr) |=> $stable(cnt));

  a_r3_upload_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[5] && !bus_wdata[4]) |=> (upl_done && cnt == $past(shadow)));

  a_r8_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[3]) |=> !wake_irq);

  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !ctrl_wr) |=> wake_irq);

  a_r7_no_wake_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_irq && !wake_en && !ctrl_wr) |=> !wake_irq);

endmodule

bind bsec_rtc bsec_rtc_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .wake_irq(wake_irq), .running(run_q),
  .wake_en(mode_q[1]), .upl_done(upl_q), .cnt(cnt_q), .shadow(shadow_q)
);

// File: tb/bsec_rtc_tb.sv
module bsec_rtc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wake_irq;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  bsec_rtc dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_irq(wake_irq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(6'h20, lo);
    rd(6'h24, hi);
    t = {hi, lo};
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic set_time(input logic [63:0] t);
    wr(6'h20, t[31:0]);
    wr(6'h24, t[63:32]);
    wr(6'h00, 32'h20);
  endtask

  task automatic set_alarm(input logic [31:0] lo, input logic [31:0] mlo);
    wr(6'h00, 32'h8);
    wr(6'h0C, lo);
    wr(6'h10, 32'h0);
    wr(6'h14, mlo);
    wr(6'h18, 32'h3FFF_FFFF);
  endtask

  task automatic t_reset_state();
    logic [31:0] d; logic [63:0] t;
    rd(6'h00, d);  chk("R1 ctrl", d, 0);
    rd_time(t);    chk("R1 time", t, 0);
    chk("R1 irq", wake_irq, 0);
    rd(6'h08, d);  chk("R1 divider", d, 0);
    rd(6'h14, d);  chk("R1 mask lo", d, 32'hFFFF_FFFF);
    rd(6'h18, d);  chk("R1 mask hi", d, 32'h3FFF_FFFF);
  endtask

  task automatic t_upload();
    logic [31:0] d; logic [63:0] t;
    wr(6'h20, 32'hDEAD_BEEF);
    wr(6'h24, 32'h2345_6789);
    rd_time(t);   chk("R2 live unchanged", t, 0);
    wr(6'h00, 32'h20);
    rd(6'h00, d); chk("R3 done bit", d[5], 1);
    rd_time(t);   chk("R3 loaded", t, 64'h2345_6789_DEAD_BEEF);
    wr(6'h20, 32'h1);
    rd(6'h00, d); chk("R3 done cleared", d[5], 0);
    rd_time(t);   chk("R2 shadow only", t, 64'h2345_6789_DEAD_BEEF);
  endtask

  task automatic t_divider();
    logic [31:0] d; logic [63:0] t;
    wr(6'h00, 32'h10);
    wr(6'h08, 32'd3);
    wr(6'h00, 32'h1);
    rd(6'h00, d); chk("R5 running", d[0], 1);
    repeat (6) @(negedge clk);
    rd_time(t);   chk("R4 no tick no count", t, 0);
    ticks(10);
    rd_time(t);   chk("R4 ten ticks div4", t, 2);
    ticks(2);
    rd_time(t);   chk("R4 twelve ticks", t, 3);
    wr(6'h00, 32'h3);
    rd(6'h00, d); chk("R5 stop wins", d[0], 0);
    ticks(8);
    rd_time(t);   chk("R5 stopped", t, 3);
    wr(6'h00, 32'h1);
    ticks(4);
    rd_time(t);   chk("R5 resumed", t, 4);
    wr(6'h08, 32'd0);
  endtask

  task automatic t_alarm_exact();
    logic [31:0] d; logic [63:0] t;
    wr(6'h00, 32'h2);
    set_time(64'h100);
    set_alarm(32'h103, 32'hFFFF_FFFF);
    wr(6'h04, 32'hA);
    wr(6'h00, 32'h5);
    ticks(2);
    chk("R6 no early irq", wake_irq, 0);
    ticks(1);
    chk("R6 irq on match", wake_irq, 1);
    rd(6'h00, d); chk("R6 match bit", d[7], 1);
    ticks(1);
    rd_time(t);   chk("R10 continue runs", t, 64'h104);
    chk("R6 sticky", wake_irq, 1);
    wr(6'h00, 32'h8);
    chk("R8 irq cleared", wake_irq, 0);
    rd(6'h00, d); chk("R8 disarmed", d[2], 0);
  endtask

  task automatic t_no_wake();
    wr(6'h00, 32'h2);
    set_time(64'h40);
    set_alarm(32'h41, 32'hFFFF_FFFF);
    wr(6'h04, 32'h8);
    wr(6'h00, 32'h5);
    ticks(2);
    chk("R7 no irq wake disabled", wake_irq, 0);
  endtask

  task automatic t_mask();
    wr(6'h00, 32'h2);
    set_time(64'h23);
    set_alarm(32'h10, 32'hFFFF_FFF0);
    wr(6'h04, 32'hA);
    wr(6'h00, 32'h4);
    @(negedge clk);
    chk("R9 bit5 differs", wake_irq, 0);
    set_time(64'h13);
    @(negedge clk);
    chk("R9 masked low bits", wake_irq, 1);
    wr(6'h00, 32'h8);
  endtask

  task automatic t_stop_on_match();
    logic [31:0] d; logic [63:0] t;
    wr(6'h00, 32'h2);
    set_time(64'h70);
    set_alarm(32'h71, 32'hFFFF_FFFF);
    wr(6'h04, 32'h2);
    wr(6'h00, 32'h5);
    ticks(1);
    rd(6'h00, d); chk("R10 stopped on match", d[0], 0);
    chk("R10 irq", wake_irq, 1);
    ticks(3);
    rd_time(t);   chk("R10 held", t, 64'h71);
    wr(6'h00, 32'h8);
  endtask

  task automatic t_wake_reset();
    logic [31:0] d; logic [63:0] t;
    wr(6'h00, 32'h2);
    set_time(64'h50);
    set_alarm(32'h52, 32'hFFFF_FFFF);
    wr(6'h04, 32'hE);
    wr(6'h00, 32'h5);
    ticks(2);
    rd_time(t);   chk("R11 restarted", t, 0);
    chk("R11 irq", wake_irq, 1);
    rd(6'h00, d); chk("R11 still running", d[0], 1);
    ticks(3);
    rd_time(t);   chk("R11 counts from zero", t, 3);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d; logic [63:0] t;
    wr(6'h00, 32'h10);
    rd_time(t);   chk("R12 time cleared", t, 0);
    chk("R12 irq cleared", wake_irq, 0);
    rd(6'h00, d); chk("R12 stopped", d[0], 0);
    ticks(2);
    rd_time(t);   chk("R12 stays stopped", t, 0);
  endtask

  task automatic t_force_irq();
    wr(6'h00, 32'h8);
    wr(6'h00, 32'h200);
    chk("R13 set", wake_irq, 1);
    wr(6'h00, 32'h100);
    chk("R13 clear", wake_irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_upload();
    t_divider();
    t_alarm_exact();
    t_no_wake();
    t_mask();
    t_stop_on_match();
    t_wake_reset();
    t_soft_reset();
    t_force_irq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule